// File: doc/BRIEF.md
# Oversampling Serial Receiver with Idle Timeout

This block is the receive half of an asynchronous serial port. A 16x baud enable pulse paces a sampler on the (synchronised) serial line. A falling level starts a frame. The start bit and every later bit are each decided by a three-sample majority taken around the middle of the bit. Eight data bits arrive least significant first, followed by one stop bit, and each finished byte is pushed into a 16-entry receive queue together with its stop-bit error flag.

Host logic drains the queue through a show-ahead read port. It sees the fill count, the empty and full flags and a sticky overrun flag. Two interrupt sources are kept apart, each with its own enable:
- A level source tracks the fill against a trigger point chosen in eighths of the queue depth.
- A timeout source flags bytes left waiting below that point once the line has been quiet for a while.

Top module: `uart_rx_ovs`

## Requirements
- R1: A frame is one low start bit, 8 data bits sent least significant bit first, then one stop bit. With each bit lasting 16 ticks of `tick16_i`, the received byte appears at `rd_data_o` when it reaches the head of the queue.
- R2: Each bit value is the majority of three samples taken on sub-ticks 7, 8 and 9 of that bit, counted from the tick on which the start was detected. A disturbance covering one of these samples has no effect, and disturbances outside them are ignored.
- R3: A start is accepted only when the majority of its centre samples is low. Otherwise the receiver returns to idle and stores no byte.
- R4: A stop bit whose majority is low stores the byte with `rd_ferr_o` = 1; a high stop bit stores it with `rd_ferr_o` = 0.
- R5: The queue holds 16 bytes in arrival order. A pulse on `rd_i` while `empty_o` is 0 removes the head entry. `fill_o` gives the count, `empty_o` is 1 at count 0 and `full_o` is 1 at count 16.
- R6: `lvl_st_o` is 1 exactly when `fill_o` >= (`level_sel_i` + 1) * 2. `irq_lvl_o` is `lvl_st_o` gated by `lvl_en_i`.
- R7: `tmo_st_o` sets once the queue has stayed non-empty for 32 bit times (512 ticks) with no accepted start. A read, or a 1 on `tmo_clr_i`, clears it and restarts the count. It never sets while the queue is empty. `irq_tmo_o` is `tmo_st_o` gated by `tmo_en_i`.
- R8: A byte that completes while the queue is full is discarded and leaves the stored data unchanged. It sets `ovr_o`, which holds until a 1 on `ovr_clr_i`.
- R9: After reset the queue is empty, the fill is 0 and every status and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulse at 16x the baud rate |
| rxd_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Pop the head entry |
| level_sel_i | input | 3 | Trigger point in eighths of depth, minus one |
| lvl_en_i | input | 1 | Level interrupt enable |
| tmo_en_i | input | 1 | Timeout interrupt enable |
| tmo_clr_i | input | 1 | Write-1 clear of the timeout status |
| ovr_clr_i | input | 1 | Write-1 clear of the overrun flag |
| rd_data_o | output | 8 | Head byte |
| rd_ferr_o | output | 1 | Framing error flag of the head byte |
| fill_o | output | 5 | Number of stored bytes |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| lvl_st_o | output | 1 | Level status, raw |
| tmo_st_o | output | 1 | Timeout status, raw |
| ovr_o | output | 1 | Overrun flag |
| irq_lvl_o | output | 1 | Level interrupt |
| irq_tmo_o | output | 1 | Timeout interrupt |

## Verification
A slipped sub-tick counter or a wrong bit index shows up on the next received byte as a wrong or shifted value at `rd_data_o`. The exhaustive sweep of all 256 byte values, together with one- and two-sample disturbances placed inside each bit centre, catches this within a frame. Corrupt queue pointers show up as out-of-order or lost bytes on the sixteen-deep fill-and-drain pass, where the level status is compared at every fill for all eight trigger settings. A wrong timeout count shows up as the status rising outside a 28 to 36 bit-time window after the last byte, or failing to clear on a read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  typedef struct packed {
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  rxd_i,
  output logic                  push_o,
  output uart_rx_pkg::rx_word_t word_o,
  output logic                  start_o
);
  import uart_rx_pkg::*;

  localparam int SW  = $clog2(OVS);
  localparam int BW  = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam int MID = OVS / 2;

  rx_state_e        state;
  logic [SW-1:0]    sub;
  logic [BW-1:0]    bidx;
  logic [1:0]       smp;
  logic [DBITS-1:0] shreg;
  logic             vote;

  // third sample taken live at sub MID+1
  assign vote = (smp[1] & smp[0]) | (smp[1] & rxd_i) | (smp[0] & rxd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      sub     <= '0;
      bidx    <= '0;
      smp     <= '0;
      shreg   <= '0;
      push_o  <= 1'b0;
      start_o <= 1'b0;
      word_o  <= '0;
    end else begin
      push_o  <= 1'b0;
      start_o <= 1'b0;
      if (tick_i) begin
        if (state == ST_IDLE) begin
          if (!rxd_i) begin
            state <= ST_START;
            sub   <= SW'(1);
          end
        end else begin
          sub <= (sub == SW'(OVS-1)) ? '0 : sub + 1'b1;
          if (sub == SW'(MID-1) || sub == SW'(MID)) smp <= {smp[0], rxd_i};
          if (sub == SW'(MID+1)) begin
            case (state)
              ST_START: if (vote) state <= ST_IDLE; else start_o <= 1'b1;
              ST_DATA:  shreg <= {vote, shreg[DBITS-1:1]};
              ST_STOP: begin
                push_o      <= 1'b1;
                word_o.ferr <= ~vote;
                word_o.data <= shreg;
                state       <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (sub == SW'(OVS-1)) begin
            if (state == ST_START) begin
              state <= ST_DATA;
              bidx  <= '0;
            end else if (state == ST_DATA) begin
              if (bidx == BW'(DBITS-1)) state <= ST_STOP;
              else bidx <= bidx + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [FW-1:0] fill_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full_o  = (fill_o == FW'(DEPTH));
  assign empty_o = (fill_o == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign data_o  = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr   <= '0;
      rptr   <= '0;
      fill_o <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      fill_o <= fill_o + 1'b1;
      else if (do_pop && !do_push) fill_o <= fill_o - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int LIMIT = 512,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic nonempty_i,
  input  logic restart_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      flag_o <= 1'b0;
    end else begin
      if (restart_i || clr_i || !nonempty_i) cnt <= '0;
      else if (tick_i && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;

      if (clr_i || !nonempty_i) flag_o <= 1'b0;
      else if (cnt == CW'(LIMIT)) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_ovs.sv
module uart_rx_ovs #(
  parameter int OVS      = 16,
  parameter int DEPTH    = 16,
  parameter int TMO_BITS = 32,
  localparam int FW      = $clog2(DEPTH + 1),
  localparam int STEP    = DEPTH / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rxd_i,
  input  logic          rd_i,
  input  logic [2:0]    level_sel_i,
  input  logic          lvl_en_i,
  input  logic          tmo_en_i,
  input  logic          tmo_clr_i,
  input  logic          ovr_clr_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_ferr_o,
  output logic [FW-1:0] fill_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          lvl_st_o,
  output logic          tmo_st_o,
  output logic          ovr_o,
  output logic          irq_lvl_o,
  output logic          irq_tmo_o
);
  import uart_rx_pkg::*;

  localparam int SYNC_N = 2;
  localparam int WW     = $bits(rx_word_t);

  logic [SYNC_N-1:0] sync_q;
  logic              push_w, start_w, drop_w, pop_w;
  rx_word_t          word_w, head_w;
  logic [FW-1:0]     trig_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], rxd_i};
  end

  uart_rx_deframer #(.OVS(OVS), .DBITS(8)) u_deframer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .rxd_i   (sync_q[SYNC_N-1]),
    .push_o  (push_w),
    .word_o  (word_w),
    .start_o (start_w)
  );

  assign pop_w = rd_i & ~empty_o;

  uart_rx_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .data_i  (word_w),
    .pop_i   (pop_w),
    .data_o  (head_w),
    .fill_o  (fill_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .drop_o  (drop_w)
  );

  uart_rx_timeout #(.LIMIT(TMO_BITS * OVS)) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .nonempty_i (~empty_o),
    .restart_i  (start_w),
    .clr_i      (pop_w | tmo_clr_i),
    .flag_o     (tmo_st_o)
  );

  // overrun: a new drop wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_o <= 1'b0;
    else if (drop_w)    ovr_o <= 1'b1;
    else if (ovr_clr_i) ovr_o <= 1'b0;
  end

  assign trig_w    = FW'((32'(level_sel_i) + 32'd1) * STEP);
  assign lvl_st_o  = (fill_o >= trig_w);
  assign irq_lvl_o = lvl_st_o & lvl_en_i;
  assign irq_tmo_o = tmo_st_o & tmo_en_i;
  assign rd_data_o = head_w.data;
  assign rd_ferr_o = head_w.ferr;
endmodule

// File: rtl/uart_rx_ovs_chk.sv
module uart_rx_ovs_chk #(
  parameter int DEPTH = 16,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          tmo_clr_i,
  input logic          ovr_clr_i,
  input logic          push_i,
  input logic [FW-1:0] fill_i,
  input logic          empty_i,
  input logic          full_i,
  input logic          tmo_st_i,
  input logic          ovr_i
);
  p_fill_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FW'(DEPTH));

  p_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_i && !push_i) |=> fill_i == FW'($past(fill_i) - 1'b1));

  p_tmo_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_clr_i || (rd_i && !empty_i)) |=> !tmo_st_i);

  p_tmo_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> !tmo_st_i);

  p_drop_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_i) |=> ovr_i);

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !ovr_clr_i) |=> ovr_i);
endmodule

bind uart_rx_ovs uart_rx_ovs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .tmo_clr_i (tmo_clr_i),
  .ovr_clr_i (ovr_clr_i),
  .push_i    (push_w),
  .fill_i    (fill_o),
  .empty_i   (empty_o),
  .full_i    (full_o),
  .tmo_st_i  (tmo_st_o),
  .ovr_i     (ovr_o)
);

// File: tb/sim_uart_rx_ovs.sv
module sim_uart_rx_ovs;
  localparam int CLK_P = 10;
  localparam int BITSL = 16;

  logic       clk, rst_n, tdiv;
  logic       rxd, rd, lvl_en, tmo_en, tmo_clr, ovr_clr;
  logic [2:0] lsel;
  logic [7:0] rdata;
  logic       ferr, empty, full, lvl_st, tmo_st, ovr, irq_lvl, irq_tmo;
  logic [4:0] fill;
  int         checks = 0;
  int         errors = 0;

  uart_rx_ovs u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tdiv), .rxd_i(rxd), .rd_i(rd),
    .level_sel_i(lsel), .lvl_en_i(lvl_en), .tmo_en_i(tmo_en),
    .tmo_clr_i(tmo_clr), .ovr_clr_i(ovr_clr), .rd_data_o(rdata),
    .rd_ferr_o(ferr), .fill_o(fill), .empty_o(empty), .full_o(full),
    .lvl_st_o(lvl_st), .tmo_st_o(tmo_st), .ovr_o(ovr),
    .irq_lvl_o(irq_lvl), .irq_tmo_o(irq_tmo)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= 1'b0;
    else        tdiv <= ~tdiv;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one sub-tick slot = one tick period = 2 clocks
  task automatic slot(input logic v);
    rxd = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // bit 0 start, 1..8 data, 9 stop; optional inverted window in one bit
  task automatic send(input logic [7:0] d, input logic stop_v,
                      input int gbit, input int gs, input int gl);
    for (int b = 0; b < 10; b++)
      for (int s = 0; s < BITSL; s++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
        if (b == gbit && s >= gs && s < gs + gl) v = ~v;
        slot(v);
      end
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    while (!empty) pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rd = 1'b0; lsel = 3'd7;
    lvl_en = 1'b1; tmo_en = 1'b1; tmo_clr = 1'b0; ovr_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 fill", fill, 0);
    chk("R9 empty", empty, 1);
    chk("R9 lvl_st", lvl_st, 0);
    chk("R9 tmo_st", tmo_st, 0);
    chk("R9 ovr", ovr, 0);
    chk("R9 irq", {irq_lvl, irq_tmo}, 0);
    idle(8);

    // R1/R4 every byte value
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1'b1, -1, 0, 0);
      idle(4);
      chk("R5 fill one", fill, 1);
      chk("R1 data", rdata, b);
      chk("R4 ferr clear", ferr, 0);
      pop();
      chk("R5 empty after read", empty, 1);
    end

    // R2 single-sample hits at centre: no effect; two-sample hits flip the bit
    for (int b = 1; b <= 8; b++) begin
      send(8'h5A, 1'b1, b, 8, 1);
      idle(4);
      chk("R2 one sample", rdata, 8'h5A);
      pop();
      send(8'h5A, 1'b1, b, 8, 2);
      idle(4);
      chk("R2 two samples", rdata, 8'h5A ^ (8'h01 << (b - 1)));
      pop();
      send(8'h5A, 1'b1, b, 2, 3);
      idle(4);
      chk("R2 off centre", rdata, 8'h5A);
      pop();
    end
    send(8'hC3, 1'b1, 0, 8, 1);
    idle(4);
    chk("R3 start glitch kept", rdata, 8'hC3);
    pop();

    // R3 short low pulse rejected, then a good frame
    for (int i = 0; i < 4; i++) slot(1'b0);
    idle(40);
    chk("R3 false start", fill, 0);
    send(8'h96, 1'b1, -1, 0, 0);
    idle(4);
    chk("R3 after false start", rdata, 8'h96);
    pop();

    // R4 low stop bit
    send(8'h3C, 1'b0, -1, 0, 0);
    idle(40);
    chk("R4 ferr fill", fill, 1);
    chk("R4 ferr data", rdata, 8'h3C);
    chk("R4 ferr set", ferr, 1);
    pop();
    drain();

    // R6 level status across all trigger settings, R8 overrun
    for (int k = 1; k <= 16; k++) begin
      send(8'(8'hA0 + k), 1'b1, -1, 0, 0);
      idle(2);
      chk("R5 fill count", fill, k);
      for (int s = 0; s < 8; s++) begin
        lsel = 3'(s);
        #1;
        chk("R6 level", lvl_st, int'(k >= (s + 1) * 2));
        chk("R6 irq", irq_lvl, int'(k >= (s + 1) * 2));
      end
    end
    chk("R5 full", full, 1);
    lvl_en = 1'b0;
    #1;
    chk("R6 irq gated", irq_lvl, 0);
    lvl_en = 1'b1;
    chk("R8 no overrun yet", ovr, 0);
    send(8'hEE, 1'b1, -1, 0, 0);
    idle(4);
    chk("R8 overrun", ovr, 1);
    chk("R8 fill held", fill, 16);
    lsel = 3'd1;
    for (int k = 1; k <= 16; k++) begin
      chk("R5 order", rdata, 8'hA0 + k);
      pop();
      chk("R6 level drain", lvl_st, int'((16 - k) >= 4));
    end
    chk("R8 dropped byte gone", empty, 1);
    chk("R8 still set", ovr, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R8 cleared", ovr, 0);

    // R7 timeout
    lsel = 3'd7;
    send(8'h42, 1'b1, -1, 0, 0);
    idle(28 * BITSL);
    chk("R7 not yet", tmo_st, 0);
    chk("R6 lvl separate", irq_lvl, 0);
    idle(8 * BITSL);
    chk("R7 set", tmo_st, 1);
    chk("R7 irq", irq_tmo, 1);
    tmo_en = 1'b0;
    #1;
    chk("R7 irq gated", irq_tmo, 0);
    tmo_en = 1'b1;
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    chk("R7 w1c", tmo_st, 0);
    idle(30 * BITSL);
    chk("R7 rearm not yet", tmo_st, 0);
    idle(4 * BITSL);
    chk("R7 rearm", tmo_st, 1);
    pop();
    chk("R7 read clears", tmo_st, 0);
    idle(40 * BITSL);
    chk("R7 empty quiet", tmo_st, 0);

    finish_run();
  end
endmodule